// File: doc/BRIEF.md
# Laser Driver Fault Supervisor

This block is the digital controller for a laser transmitter. It decides when the bias current source and the modulation current source are switched on. It produces a soft-start code that brings the delivered current up in steps rather than in one jump. It also watches three fault comparators: bias monitor over threshold, photodiode monitor over threshold, and a short-to-rail detector on the setting pins. When any of them reports a fault, the block raises a shutdown flag.

A mode input selects one of two fault policies. In latched mode, a fault switches both current sources off and holds the shutdown flag high. The latch is cleared only by holding the asynchronous disable input high for a qualified number of cycles; shorter spikes on that input are ignored. In transparent mode, the shutdown flag simply follows the fault condition and the current sources keep running. Losing the supply-good flag returns everything to the initial state, including any latched fault.

Top module: `ldrv_fault_sup`

## Requirements
- R1: After reset, and while `supply_ok` is low, `shutdown`, `bias_en`, `mod_en`, `init_done` and `ramp_code` are all zero.
- R2: When supply is good and disable is low, both enables turn on with `ramp_code` = 0. The code then rises by `RAMP_STEP` every cycle, saturating at full scale (2^`RAMP_W` - 1), and holds there.
- R3: `init_done` is high exactly when `ramp_code` is at or above ceil(95 % of full scale).
- R4: If disable is high when supply becomes good, no enable turns on and the ramp stays at zero. Both enables come on, with code 0, on the third clock edge after disable falls.
- R5: Raising disable during operation clears both enables and the ramp code on the third clock edge. Releasing disable restarts the ramp from zero.
- R6: With `soft_mode` = 0, a fault raises `shutdown` and clears both enables on the next edge. Both stay that way after the fault goes away.
- R7: With `soft_mode` = 1, a fault raises `shutdown` on the next edge while the enables stay on. `shutdown` falls on the edge after the fault goes away.
- R8: A latched fault is cleared only by disable held high for at least max(`HOLD_CYC`, `SPIKE_CYC`+1) consecutive cycles. Any shorter pulse leaves the latch set.
- R9: After a clear, `shutdown` is low and the start-up sequence runs again from code 0 once disable is low.
- R10: Dropping `supply_ok` returns the block to its initial outputs on the next edge and discards a latched fault.
- R11: Each of the three fault flags alone is enough to cause a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| supply_ok | input | 1 | Supply above its good threshold |
| disable_in | input | 1 | Asynchronous disable / fault-clear input |
| soft_mode | input | 1 | 1 = transparent fault flag, 0 = latched shutdown |
| flt_bias | input | 1 | Bias monitor over threshold |
| flt_pd | input | 1 | Photodiode monitor over threshold |
| flt_short | input | 1 | Setting-pin short detected |
| shutdown | output | 1 | Fault indication |
| bias_en | output | 1 | Bias current source enable |
| mod_en | output | 1 | Modulation current source enable |
| ramp_code | output | RAMP_W | Soft-start code |
| init_done | output | 1 | Ramp has reached 95 % of full scale |

## Verification
Fault inputs and `supply_ok` act on the next clock edge. Disable passes through two synchronizer flops and one state register, so its effect on the enables appears on the third edge. A disable pulse of L cycles clears the latch only when L reaches the hold length. The bench drives inputs on the falling edge and samples on the falling edges that match these counts. It checks the cycle just before each deadline as well as the deadline itself, which pins the latency exactly. The ramp code is compared every cycle against a saturating sum computed in the bench. Pulse lengths from one cycle up to the hold length are swept, and every fault source is tried in both modes.

// File: rtl/ldrv_sup_pkg.sv
`timescale 1ns/1ps
package ldrv_sup_pkg;

  typedef enum logic [1:0] {
    LS_OFF  = 2'd0,
    LS_RAMP = 2'd1,
    LS_RUN  = 2'd2,
    LS_HARD = 2'd3
  } ls_state_t;

  // saturating ramp increment
  function automatic int unsigned ramp_next(input int unsigned code,
                                            input int unsigned step,
                                            input int unsigned fs);
    int unsigned s;
    s = code + step;
    return (s > fs) ? fs : s;
  endfunction

  // smallest code at or above 95 % of full scale
  function automatic int unsigned thr95(input int unsigned fs);
    return (fs * 95 + 99) / 100;
  endfunction

endpackage

// File: rtl/ldrv_sync2.sv
`timescale 1ns/1ps
module ldrv_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic ff1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1    <= 1'b0;
      q_sync <= 1'b0;
    end else begin
      ff1    <= d_async;
      q_sync <= ff1;
    end
  end
endmodule

// File: rtl/ldrv_hold_qual.sv
`timescale 1ns/1ps
module ldrv_hold_qual #(
  parameter int CLR_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic clr_pulse
);
  localparam int CW = $clog2(CLR_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(CLR_CYC);
  localparam logic [CW-1:0] CNT_HIT = CW'(CLR_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!lvl)           cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // one pulse on the CLR_CYC-th consecutive high cycle
  assign clr_pulse = lvl && (cnt == CNT_HIT);
endmodule

// File: rtl/ldrv_ramp.sv
`timescale 1ns/1ps
module ldrv_ramp #(
  parameter int RAMP_W    = 8,
  parameter int RAMP_STEP = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [RAMP_W-1:0] code,
  output logic              full,
  output logic              done
);
  localparam int unsigned FS  = (1 << RAMP_W) - 1;
  localparam int unsigned THR = ldrv_sup_pkg::thr95(FS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   code <= '0;
    else if (clr) code <= '0;
    else if (adv) code <= RAMP_W'(ldrv_sup_pkg::ramp_next(32'(code), RAMP_STEP, FS));
  end

  assign full = (32'(code) == FS);
  assign done = (32'(code) >= THR);
endmodule

// File: rtl/ldrv_fault_sup.sv
`timescale 1ns/1ps
module ldrv_fault_sup #(
  parameter int RAMP_W    = 8,
  parameter int RAMP_STEP = 10,
  parameter int SPIKE_CYC = 4,
  parameter int HOLD_CYC  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              disable_in,
  input  logic              soft_mode,
  input  logic              flt_bias,
  input  logic              flt_pd,
  input  logic              flt_short,
  output logic              shutdown,
  output logic              bias_en,
  output logic              mod_en,
  output logic [RAMP_W-1:0] ramp_code,
  output logic              init_done
);
  import ldrv_sup_pkg::*;

  localparam int CLR_CYC = (HOLD_CYC > SPIKE_CYC) ? HOLD_CYC : SPIKE_CYC + 1;

  ls_state_t state, nxt;
  logic dis_s, clr_pulse, fault_any, st_hard, ramp_full;
  logic en_now, en_nxt, sd_q;

  ldrv_sync2 u_sync (.clk(clk), .rst_n(rst_n), .d_async(disable_in), .q_sync(dis_s));

  ldrv_hold_qual #(.CLR_CYC(CLR_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .lvl(dis_s), .clr_pulse(clr_pulse));

  assign fault_any = flt_bias | flt_pd | flt_short;

  // latched-mode fault wins over a clear in the same cycle
  always_comb begin
    nxt = state;
    if (!supply_ok)                   nxt = LS_OFF;
    else if (fault_any && !soft_mode) nxt = LS_HARD;
    else begin
      case (state)
        LS_OFF:  if (!dis_s) nxt = LS_RAMP;
        LS_RAMP: if (dis_s) nxt = LS_OFF; else if (ramp_full) nxt = LS_RUN;
        LS_RUN:  if (dis_s) nxt = LS_OFF;
        LS_HARD: if (clr_pulse) nxt = LS_OFF;
        default: nxt = LS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LS_OFF;
      sd_q  <= 1'b0;
    end else begin
      state <= nxt;
      sd_q  <= (nxt == LS_HARD) | (supply_ok & soft_mode & fault_any);
    end
  end

  assign en_now  = (state == LS_RAMP) || (state == LS_RUN);
  assign en_nxt  = (nxt == LS_RAMP) || (nxt == LS_RUN);
  assign st_hard = (state == LS_HARD);

  ldrv_ramp #(.RAMP_W(RAMP_W), .RAMP_STEP(RAMP_STEP)) u_ramp (
    .clk(clk), .rst_n(rst_n),
    .clr(!en_nxt), .adv(en_now && en_nxt),
    .code(ramp_code), .full(ramp_full), .done(init_done));

  assign shutdown = sd_q;
  assign bias_en  = en_now;
  assign mod_en   = en_now;
endmodule

// File: rtl/ldrv_fault_sup_chk.sv
`timescale 1ns/1ps
module ldrv_fault_sup_chk #(
  parameter int RAMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              soft_mode,
  input logic              fault_any,
  input logic              dis_s,
  input logic              st_hard,
  input logic              clr_pulse,
  input logic              shutdown,
  input logic              bias_en,
  input logic              mod_en,
  input logic [RAMP_W-1:0] ramp_code,
  input logic              init_done
);
  assert_off_nosupply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!shutdown && !bias_en && !mod_en && ramp_code == '0));

  assert_hard_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !soft_mode && fault_any) |=> (shutdown && !bias_en && !mod_en));

  assert_soft_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && soft_mode && fault_any) |=> shutdown);

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && st_hard && !clr_pulse) |=> st_hard);

  assert_dis_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dis_s |=> !bias_en);

  assert_ramp_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_en && $past(bias_en)) |-> (ramp_code > $past(ramp_code) || (&ramp_code)));

  assert_done_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (bias_en && mod_en));
endmodule

bind ldrv_fault_sup ldrv_fault_sup_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .soft_mode(soft_mode),
  .fault_any(fault_any), .dis_s(dis_s), .st_hard(st_hard), .clr_pulse(clr_pulse),
  .shutdown(shutdown), .bias_en(bias_en), .mod_en(mod_en),
  .ramp_code(ramp_code), .init_done(init_done));

// File: tb/ldrv_fault_sup_tb.sv
`timescale 1ns/1ps
module ldrv_fault_sup_tb;
  localparam int W    = 8;
  localparam int STEP = 10;
  localparam int SPK  = 4;
  localparam int HOLD = 12;
  localparam int FS   = 255;
  localparam int THR  = (FS * 95 + 99) / 100;
  localparam int CLR  = (HOLD > SPK) ? HOLD : SPK + 1;

  logic clk = 1'b0;
  logic rst_n, supply_ok, disable_in, soft_mode, flt_bias, flt_pd, flt_short;
  logic shutdown, bias_en, mod_en, init_done;
  logic [W-1:0] ramp_code;
  int n_cmp = 0;
  int n_bad = 0;
  bit fin = 0;

  always #2 clk = ~clk;

  ldrv_fault_sup #(.RAMP_W(W), .RAMP_STEP(STEP), .SPIKE_CYC(SPK), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .disable_in(disable_in),
    .soft_mode(soft_mode), .flt_bias(flt_bias), .flt_pd(flt_pd), .flt_short(flt_short),
    .shutdown(shutdown), .bias_en(bias_en), .mod_en(mod_en),
    .ramp_code(ramp_code), .init_done(init_done));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ramp_from_entry(input string req);
    int e = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      e = (e + STEP > FS) ? FS : e + STEP;
      chk(req, int'(ramp_code), e);
      chk("R3", int'(init_done), int'(e >= THR));
      chk(req, int'(bias_en & mod_en), 1);
    end
  endtask

  task automatic pulse_dis(input int len);
    @(negedge clk);
    disable_in = 1'b1;
    repeat (len) @(negedge clk);
    disable_in = 1'b0;
  endtask

  task automatic expect_restart(input string req);
    repeat (2) @(negedge clk);
    chk(req, int'(bias_en), 0);
    @(negedge clk);
    chk(req, int'(bias_en & mod_en), 1);
    chk(req, int'(ramp_code), 0);
    chk(req, int'(shutdown), 0);
  endtask

  task automatic set_flag(input int src, input logic v);
    case (src)
      0:       flt_bias  = v;
      1:       flt_pd    = v;
      default: flt_short = v;
    endcase
  endtask

  initial begin
    #800000;
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; supply_ok = 0; disable_in = 0; soft_mode = 0;
    flt_bias = 0; flt_pd = 0; flt_short = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", int'(shutdown), 0);
    chk("R1", int'(bias_en | mod_en), 0);
    chk("R1", int'(ramp_code), 0);
    chk("R1", int'(init_done), 0);

    // R2: ramp after supply good
    supply_ok = 1;
    @(negedge clk);
    chk("R2", int'(bias_en & mod_en), 1);
    chk("R2", int'(ramp_code), 0);
    ramp_from_entry("R2");

    // R5: disable during operation
    @(negedge clk);
    disable_in = 1;
    repeat (2) @(negedge clk);
    chk("R5", int'(bias_en), 1);
    @(negedge clk);
    chk("R5", int'(bias_en | mod_en), 0);
    chk("R5", int'(ramp_code), 0);
    repeat (3) @(negedge clk);
    disable_in = 0;
    expect_restart("R5");
    ramp_from_entry("R5");

    // R6 / R7 / R11: every source in both modes
    for (int m = 0; m < 2; m++) begin
      for (int src = 0; src < 3; src++) begin
        @(negedge clk);
        soft_mode = logic'(m);
        set_flag(src, 1'b1);
        @(negedge clk);
        chk("R11", int'(shutdown), 1);
        chk(m ? "R7" : "R6", int'(bias_en | mod_en), m);
        set_flag(src, 1'b0);
        if (m == 1) begin
          @(negedge clk);
          chk("R7", int'(shutdown), 0);
          chk("R7", int'(bias_en & mod_en), 1);
        end else begin
          repeat (5) @(negedge clk);
          chk("R6", int'(shutdown), 1);
          chk("R6", int'(bias_en | mod_en), 0);
          pulse_dis(CLR);
          expect_restart("R9");
          ramp_from_entry("R9");
        end
      end
    end

    // R8: pulse length sweep against the latch
    @(negedge clk);
    soft_mode = 0; flt_pd = 1;
    @(negedge clk);
    flt_pd = 0;
    chk("R8", int'(shutdown), 1);
    for (int len = 1; len < CLR; len++) begin
      pulse_dis(len);
      repeat (6) @(negedge clk);
      chk("R8", int'(shutdown), 1);
      chk("R8", int'(bias_en), 0);
    end
    pulse_dis(CLR);
    expect_restart("R8");
    ramp_from_entry("R9");

    // R4: disable high at power-up
    @(negedge clk);
    supply_ok = 0; disable_in = 1;
    @(negedge clk);
    chk("R1", int'(bias_en | shutdown), 0);
    repeat (4) @(negedge clk);
    supply_ok = 1;
    repeat (10) @(negedge clk);
    chk("R4", int'(bias_en | mod_en), 0);
    chk("R4", int'(ramp_code), 0);
    disable_in = 0;
    expect_restart("R4");
    ramp_from_entry("R4");

    // R10: supply loss discards a latched fault
    @(negedge clk);
    flt_short = 1;
    @(negedge clk);
    flt_short = 0;
    chk("R10", int'(shutdown), 1);
    supply_ok = 0;
    @(negedge clk);
    chk("R10", int'(shutdown), 0);
    chk("R10", int'(bias_en | mod_en), 0);
    chk("R10", int'(ramp_code), 0);
    supply_ok = 1;
    @(negedge clk);
    chk("R10", int'(bias_en & mod_en), 1);
    chk("R10", int'(ramp_code), 0);
    ramp_from_entry("R10");

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule